// File: doc/BRIEF.md
# Scheduled Second-Order Digital Compensator

This block is the control side of a plant-emulation loop. A plant emulator advances its model once per plant step and signals each step with a one-cycle tick. Every `RATIO` plant steps (ten by default), the compensator runs one control period. It asks the plant for its capacitor voltage and waits for the answer. It then forms the error against a reference and evaluates a two-pole, two-zero difference equation. That equation is the discrete form of a PI compensator with a high-frequency roll-off. The block then publishes a new duty cycle and idles until the next period boundary.

The recursion keeps two past outputs and two past errors. Its five coefficients are signed Q4.12 register inputs, and the block does not compute them. A single shared multiply-accumulate unit evaluates the five products in five consecutive cycles. The result is clamped to a programmable duty window. The clamped value is also what goes into the output history, which keeps the integrator from winding up while the output is saturated.

The duty register changes only at a publish. The plant reads it at its own next step boundary, which on average adds half a plant step of delay.

Top module: `pi_rolloff_comp`

## Requirements
- R1: While `rst_n` is low at a rising edge, the block resets. `duty_out` takes the value of `duty_init`, `st_req` and `duty_pub` go low, and all four history terms (two past outputs, two past errors) become zero.
- R2: The first `step_tick` after reset opens a control period, and so does every `RATIO`-th tick after it. `st_req` goes high in the cycle that follows the opening tick.
- R3: `st_req` stays high until a cycle in which `st_ack` is high. The block ignores `st_ack` at any other time.
- R4: In the acknowledge cycle, the error is latched as `ref_v - st_vc`, computed in two's complement and saturated to the signed `DW`-bit range (+32767 / -32768 at the default width).
- R5: The new output is u = floor((A·u1 + B·u2 + C·e0 + D·e1 + E·e2) / 2^CFRAC). The coefficients are signed with `CFRAC` = 12 fractional bits. u1 and u2 are the two previous published duties and e1 and e2 are the two previous errors. The coefficients are read during the five cycles that follow the acknowledge.
- R6: The new duty appears on `duty_out` at the sixth rising edge after the edge that samples the acknowledge. `duty_pub` is high for exactly that one following cycle.
- R7: The result is clamped to [`duty_min`, `duty_max`], read in the publish cycle. These bounds are unsigned `DW-1`-bit values, where 2^(DW-1) stands for a duty of 1.0. The clamped value, not the raw sum, becomes u1 for the next period.
- R8: Apart from reset and publishes, `duty_out` holds its value.
- R9: A period boundary tick that arrives while the previous period has not yet reached idle starts no period. The tick counter still counts it, so the next period opens `RATIO` ticks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step_tick | input | 1 | One-cycle pulse per plant step |
| st_req | output | 1 | Plant state request, held until acknowledged |
| st_ack | input | 1 | Plant answers the request; `st_vc` is valid |
| st_vc | input | DW | Signed capacitor voltage from the plant |
| ref_v | input | DW | Signed voltage reference |
| coef_a | input | CW | Coefficient on u1 (Q4.12) |
| coef_b | input | CW | Coefficient on u2 (Q4.12) |
| coef_c | input | CW | Coefficient on e0 (Q4.12) |
| coef_d | input | CW | Coefficient on e1 (Q4.12) |
| coef_e | input | CW | Coefficient on e2 (Q4.12) |
| duty_min | input | DW-1 | Lower duty clamp |
| duty_max | input | DW-1 | Upper duty clamp |
| duty_init | input | DW-1 | Duty loaded by reset |
| duty_out | output | DW-1 | Current duty cycle |
| duty_pub | output | 1 | High in the first cycle a new duty is shown |

## Verification
Two pairs of events can fall in the same cycle. A plant-step tick can arrive together with the state acknowledge, and a tick can arrive together with the duty publish. In either case the tick must still be counted toward the schedule while the period's own sequence advances.

These coincidences are provoked by running the plant with a tick in every cycle. One run acknowledges at once, so no period is lost. Another run delays the acknowledge, so a period boundary falls on a busy period and must be dropped.

The design is judged on every clock against a behavioural model that counts ticks on its own. The bench also checks the number of ticks between successive rising edges of the request. It also checks the gap of seven observed cycles from acknowledge to publish.

// File: rtl/comp2_pkg.sv
// Package: shared types of the scheduled compensator.
// Assumes: the recursion always has five product terms.
package comp2_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_REQ  = 2'd1,
        PH_MAC  = 2'd2,
        PH_PUB  = 2'd3
    } comp2_phase_e;

    localparam int unsigned NTAPS = 5;

endpackage

// File: rtl/comp2_sched.sv
// Module: comp2_sched
// Counts plant-step ticks. On every RATIO-th tick, if idle, it walks one
// control period through request, five accumulate cycles and publish.
// Assumes: step_tick is a single-cycle pulse; st_ack matters only in request.
module comp2_sched
    import comp2_pkg::*;
#(
    parameter int unsigned RATIO = 10,
    parameter int unsigned IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_tick,
    input  logic             st_ack,
    output logic             st_req,
    output logic             latch_en,
    output logic             mac_en,
    output logic [IDX_W-1:0] mac_idx,
    output logic             pub_en
);

    localparam int unsigned      CNT_W    = (RATIO > 1) ? $clog2(RATIO) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RATIO - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NTAPS - 1);

    comp2_phase_e     ph_q;
    logic [CNT_W-1:0] cnt_q;
    logic [IDX_W-1:0] idx_q;
    logic             period_start;

    assign period_start = step_tick && (cnt_q == '0) && (ph_q == PH_IDLE);
    assign st_req       = (ph_q == PH_REQ);
    assign latch_en     = st_req && st_ack;
    assign mac_en       = (ph_q == PH_MAC);
    assign pub_en       = (ph_q == PH_PUB);
    assign mac_idx      = idx_q;

    // Tick counter: position inside the control period, busy or not.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (step_tick) begin
            cnt_q <= (cnt_q == CNT_LAST) ? '0 : cnt_q + CNT_W'(1);
        end
    end

    // Phase sequencer: idle -> request -> accumulate x5 -> publish -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q  <= PH_IDLE;
            idx_q <= '0;
        end else begin
            case (ph_q)
                PH_IDLE: if (period_start) ph_q <= PH_REQ;
                PH_REQ: begin
                    if (st_ack) begin
                        ph_q  <= PH_MAC;
                        idx_q <= '0;
                    end
                end
                PH_MAC: begin
                    idx_q <= idx_q + IDX_W'(1);
                    if (idx_q == IDX_LAST) ph_q <= PH_PUB;
                end
                PH_PUB:  ph_q <= PH_IDLE;
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    // R2
    start_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        period_start |=> st_req);

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_req && !st_ack) |=> st_req);

    // R5
    mac_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mac_en && (mac_idx != IDX_LAST)) |=> (mac_en && (mac_idx == $past(mac_idx) + IDX_W'(1))));

    // R9
    busy_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_tick && (mac_en || pub_en)) |=> !st_req);

endmodule

// File: rtl/comp2_mac.sv
// Module: comp2_mac
// Single signed multiplier with an accumulator, shared by all five terms.
// Assumes: ACCW has enough guard bits above CW+DW for five products.
module comp2_mac #(
    parameter int unsigned CW   = 16,
    parameter int unsigned DW   = 16,
    parameter int unsigned ACCW = 35
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr,
    input  logic                   en,
    input  logic signed [CW-1:0]   coef,
    input  logic signed [DW-1:0]   data,
    output logic signed [ACCW-1:0] acc
);

    localparam int unsigned PW = CW + DW;

    logic signed [PW-1:0]   prod;
    logic signed [ACCW-1:0] acc_q;

    assign prod = PW'(coef) * PW'(data);
    assign acc  = acc_q;

    // Accumulator: cleared at the start of a period, adds one product per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (clr) begin
            acc_q <= '0;
        end else if (en) begin
            acc_q <= acc_q + ACCW'(prod);
        end
    end

endmodule

// File: rtl/comp2_hist.sv
// Module: comp2_hist
// Latches the saturated error. At publish it clamps the scaled sum into the
// duty window, loads the duty register and shifts both history pairs.
// Assumes: duty_min <= duty_max; 2^(DW-1) in duty units stands for 1.0.
module comp2_hist #(
    parameter int unsigned DW    = 16,
    parameter int unsigned ACCW  = 35,
    parameter int unsigned CFRAC = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   latch_en,
    input  logic                   pub_en,
    input  logic signed [DW-1:0]   st_vc,
    input  logic signed [DW-1:0]   ref_v,
    input  logic signed [ACCW-1:0] acc,
    input  logic [DW-2:0]          duty_min,
    input  logic [DW-2:0]          duty_max,
    input  logic [DW-2:0]          duty_init,
    output logic signed [DW-1:0]   e0,
    output logic signed [DW-1:0]   e1,
    output logic signed [DW-1:0]   e2,
    output logic signed [DW-1:0]   u1,
    output logic signed [DW-1:0]   u2,
    output logic [DW-2:0]          duty_out,
    output logic                   duty_pub
);

    localparam int unsigned UW = DW - 1;

    logic signed [DW:0]     diff;
    logic signed [DW-1:0]   e_new;
    logic signed [ACCW-1:0] scaled;
    logic signed [ACCW-1:0] lo_ext;
    logic signed [ACCW-1:0] hi_ext;
    logic [UW-1:0]          u_new;
    logic signed [DW-1:0]   e0_q, e1_q, e2_q;
    logic [UW-1:0]          u1_q, u2_q, duty_q;
    logic                   pub_q;

    // Error: one extra bit for the subtraction, then saturate back to DW bits.
    always_comb begin
        diff = {ref_v[DW-1], ref_v} - {st_vc[DW-1], st_vc};
        if (diff[DW] != diff[DW-1]) begin
            e_new = diff[DW] ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}};
        end else begin
            e_new = diff[DW-1:0];
        end
    end

    // Scale the sum back to duty units and clamp it to the window.
    always_comb begin
        scaled = acc >>> CFRAC;
        lo_ext = $signed({{(ACCW-UW){1'b0}}, duty_min});
        hi_ext = $signed({{(ACCW-UW){1'b0}}, duty_max});
        if (scaled < lo_ext) begin
            u_new = duty_min;
        end else if (scaled > hi_ext) begin
            u_new = duty_max;
        end else begin
            u_new = scaled[UW-1:0];
        end
    end

    // Error snapshot taken in the acknowledge cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e0_q <= '0;
        end else if (latch_en) begin
            e0_q <= e_new;
        end
    end

    // Publish: duty register and both history pairs advance together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e1_q   <= '0;
            e2_q   <= '0;
            u1_q   <= '0;
            u2_q   <= '0;
            duty_q <= duty_init;
        end else if (pub_en) begin
            e1_q   <= e0_q;
            e2_q   <= e1_q;
            u1_q   <= u_new;
            u2_q   <= u1_q;
            duty_q <= u_new;
        end
    end

    // Publish marker, high for the first cycle of the new duty.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pub_q <= 1'b0;
        end else begin
            pub_q <= pub_en;
        end
    end

    assign e0       = e0_q;
    assign e1       = e1_q;
    assign e2       = e2_q;
    assign u1       = $signed({1'b0, u1_q});
    assign u2       = $signed({1'b0, u2_q});
    assign duty_out = duty_q;
    assign duty_pub = pub_q;

    // R4
    err_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        latch_en |=> (($past(ref_v) >= $past(st_vc)) == !e0_q[DW-1]));

    // R7
    duty_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        duty_pub |-> ((duty_out >= $past(duty_min)) && (duty_out <= $past(duty_max))));

    // R8
    duty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pub_en |=> $stable(duty_out));

endmodule

// File: rtl/pi_rolloff_comp.sv
// Module: pi_rolloff_comp (top)
// Two-pole, two-zero compensator that runs once per RATIO plant steps.
// Wires the scheduler, the shared multiply-accumulate and the history
// block, and picks the coefficient and operand for each accumulate cycle.
// Assumes: coefficients are signed Q(CW-CFRAC).CFRAC; duty 1.0 = 2^(DW-1).
module pi_rolloff_comp
    import comp2_pkg::*;
#(
    parameter int unsigned DW    = 16,
    parameter int unsigned CW    = 16,
    parameter int unsigned CFRAC = 12,
    parameter int unsigned RATIO = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 step_tick,
    output logic                 st_req,
    input  logic                 st_ack,
    input  logic signed [DW-1:0] st_vc,
    input  logic signed [DW-1:0] ref_v,
    input  logic signed [CW-1:0] coef_a,
    input  logic signed [CW-1:0] coef_b,
    input  logic signed [CW-1:0] coef_c,
    input  logic signed [CW-1:0] coef_d,
    input  logic signed [CW-1:0] coef_e,
    input  logic [DW-2:0]        duty_min,
    input  logic [DW-2:0]        duty_max,
    input  logic [DW-2:0]        duty_init,
    output logic [DW-2:0]        duty_out,
    output logic                 duty_pub
);

    localparam int unsigned ACCW  = CW + DW + $clog2(NTAPS);
    localparam int unsigned IDX_W = $clog2(NTAPS);

    logic                   latch_en, mac_en, pub_en;
    logic [IDX_W-1:0]       mac_idx;
    logic signed [CW-1:0]   op_coef;
    logic signed [DW-1:0]   op_data;
    logic signed [ACCW-1:0] acc;
    logic signed [DW-1:0]   e0, e1, e2, u1, u2;

    comp2_sched #(
        .RATIO (RATIO),
        .IDX_W (IDX_W)
    ) u_sched (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_tick (step_tick),
        .st_ack    (st_ack),
        .st_req    (st_req),
        .latch_en  (latch_en),
        .mac_en    (mac_en),
        .mac_idx   (mac_idx),
        .pub_en    (pub_en)
    );

    // Operand select: one coefficient/history pair per accumulate cycle.
    always_comb begin
        case (mac_idx)
            IDX_W'(1): begin op_coef = coef_b; op_data = u2; end
            IDX_W'(2): begin op_coef = coef_c; op_data = e0; end
            IDX_W'(3): begin op_coef = coef_d; op_data = e1; end
            IDX_W'(4): begin op_coef = coef_e; op_data = e2; end
            default:   begin op_coef = coef_a; op_data = u1; end
        endcase
    end

    comp2_mac #(
        .CW   (CW),
        .DW   (DW),
        .ACCW (ACCW)
    ) u_mac (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (latch_en),
        .en    (mac_en),
        .coef  (op_coef),
        .data  (op_data),
        .acc   (acc)
    );

    comp2_hist #(
        .DW    (DW),
        .ACCW  (ACCW),
        .CFRAC (CFRAC)
    ) u_hist (
        .clk       (clk),
        .rst_n     (rst_n),
        .latch_en  (latch_en),
        .pub_en    (pub_en),
        .st_vc     (st_vc),
        .ref_v     (ref_v),
        .acc       (acc),
        .duty_min  (duty_min),
        .duty_max  (duty_max),
        .duty_init (duty_init),
        .e0        (e0),
        .e1        (e1),
        .e2        (e2),
        .u1        (u1),
        .u2        (u2),
        .duty_out  (duty_out),
        .duty_pub  (duty_pub)
    );

endmodule

// File: tb/pi_rolloff_comp_tb.sv
// Bench: a behavioural model updated on every rising edge and compared with
// the design at each falling edge. Scenario checks cover spacing, latency,
// clamping and error saturation.
module pi_rolloff_comp_tb;

    localparam int DW    = 16;
    localparam int CW    = 16;
    localparam int CFRAC = 12;
    localparam int RATIO = 10;
    localparam int WD_CYC = 20000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic step_tick = 1'b0;
    logic st_ack = 1'b0;
    logic signed [DW-1:0] st_vc = '0;
    logic signed [DW-1:0] ref_v = '0;
    logic signed [CW-1:0] coef_a = '0, coef_b = '0, coef_c = '0, coef_d = '0, coef_e = '0;
    logic [DW-2:0] duty_min = '0, duty_max = '0, duty_init = '0;
    logic st_req;
    logic [DW-2:0] duty_out;
    logic duty_pub;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #2.5 clk = ~clk;

    pi_rolloff_comp #(.DW(DW), .CW(CW), .CFRAC(CFRAC), .RATIO(RATIO)) u_dut (
        .clk(clk), .rst_n(rst_n), .step_tick(step_tick), .st_req(st_req),
        .st_ack(st_ack), .st_vc(st_vc), .ref_v(ref_v),
        .coef_a(coef_a), .coef_b(coef_b), .coef_c(coef_c), .coef_d(coef_d), .coef_e(coef_e),
        .duty_min(duty_min), .duty_max(duty_max), .duty_init(duty_init),
        .duty_out(duty_out), .duty_pub(duty_pub)
    );

    // ---------------- reference model ----------------
    int m_ph, m_cnt, m_idx;
    longint m_acc;
    int m_e0, m_e1, m_e2, m_u1, m_u2, m_duty;
    bit m_pub;

    function automatic int sat_dw(int v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic longint term(int idx);
        case (idx)
            0: return longint'(int'(coef_a)) * m_u1;
            1: return longint'(int'(coef_b)) * m_u2;
            2: return longint'(int'(coef_c)) * m_e0;
            3: return longint'(int'(coef_d)) * m_e1;
            default: return longint'(int'(coef_e)) * m_e2;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_cnt = 0; m_idx = 0; m_acc = 0;
            m_e0 = 0; m_e1 = 0; m_e2 = 0; m_u1 = 0; m_u2 = 0;
            m_duty = int'(duty_init); m_pub = 0;
        end else begin
            bit start;
            longint r;
            start = step_tick && (m_cnt == 0) && (m_ph == 0);
            if (step_tick) m_cnt = (m_cnt == RATIO - 1) ? 0 : m_cnt + 1;
            m_pub = 0;
            case (m_ph)
                0: if (start) m_ph = 1;
                1: if (st_ack) begin
                       m_e0 = sat_dw(int'(ref_v) - int'(st_vc));
                       m_acc = 0; m_idx = 0; m_ph = 2;
                   end
                2: begin
                       m_acc = m_acc + term(m_idx);
                       if (m_idx == 4) m_ph = 3;
                       m_idx = m_idx + 1;
                   end
                default: begin
                       r = m_acc >>> CFRAC;
                       if (r < longint'(duty_min)) r = longint'(duty_min);
                       else if (r > longint'(duty_max)) r = longint'(duty_max);
                       m_u2 = m_u1; m_u1 = int'(r);
                       m_e2 = m_e1; m_e1 = m_e0;
                       m_duty = int'(r); m_pub = 1; m_ph = 0;
                   end
            endcase
        end
    end

    // ---------------- checking ----------------
    task automatic chk(bit ok, string tag, string what, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // scenario controls
    int  gap, ack_lat, spacing_exp;
    bit  stray, force_vc, exp_hi, exp_lo;
    int  force_val, exp_val;
    // running state
    int  gcnt, req_wait, tick_since, lat_cnt, cyc, vc_plant;
    bit  req_prev, first_rise, lat_armed;

    task automatic one_cycle();
        bit rise;
        @(negedge clk);
        cyc++;
        // per-clock comparison against the model
        chk(st_req == (m_ph == 1), "R3", "st_req", int'(st_req), int'(m_ph == 1));
        chk(duty_pub == m_pub, "R6", "duty_pub", int'(duty_pub), int'(m_pub));
        chk(int'(duty_out) == m_duty, "R5", "duty_out", int'(duty_out), m_duty);
        // request spacing in ticks
        rise = st_req && !req_prev;
        if (rise) begin
            if (!first_rise && spacing_exp > 0)
                chk(tick_since == spacing_exp, (spacing_exp == RATIO) ? "R2" : "R9",
                    "ticks between requests", tick_since, spacing_exp);
            first_rise = 0;
            tick_since = 0;
        end
        if (lat_armed) lat_cnt++;
        if (duty_pub) begin
            if (lat_armed) chk(lat_cnt == 7, "R6", "cycles ack->publish", lat_cnt, 7);
            lat_armed = 0;
            if (exp_hi) chk(duty_out == duty_max, "R7", "upper clamp", int'(duty_out), int'(duty_max));
            if (exp_lo) chk(duty_out == duty_min, "R7", "lower clamp", int'(duty_out), int'(duty_min));
            if (exp_val >= 0) chk(int'(duty_out) == exp_val, "R4", "saturated error", int'(duty_out), exp_val);
        end
        req_prev = st_req;
        // drive the next cycle: plant step tick and plant emulator
        step_tick = (gcnt == 0);
        gcnt = (gcnt >= gap - 1) ? 0 : gcnt + 1;
        if (step_tick) begin
            tick_since++;
            vc_plant = vc_plant + ((int'(duty_out) / 2 - vc_plant) >>> 3);
        end
        st_vc = force_vc ? DW'(force_val) : DW'(vc_plant);
        if (st_req) begin
            st_ack = (req_wait == ack_lat);
            if (st_ack) begin lat_armed = 1; lat_cnt = 0; end
            req_wait++;
        end else begin
            req_wait = 0;
            st_ack = stray && (cyc % 5 == 2);
        end
    endtask

    task automatic do_reset(int init_v);
        @(negedge clk);
        rst_n = 1'b0; step_tick = 1'b0; st_ack = 1'b0; duty_init = DW'(init_v);
        repeat (3) @(negedge clk);
        // R1
        chk(int'(duty_out) == init_v, "R1", "duty after reset", int'(duty_out), init_v);
        chk(st_req == 1'b0, "R1", "st_req after reset", int'(st_req), 0);
        chk(duty_pub == 1'b0, "R1", "duty_pub after reset", int'(duty_pub), 0);
        gcnt = 0; req_wait = 0; tick_since = 0; lat_cnt = 0; vc_plant = 0;
        req_prev = 0; first_rise = 1; lat_armed = 0;
        exp_hi = 0; exp_lo = 0; exp_val = -1; force_vc = 0; stray = 0;
        st_vc = '0;
        rst_n = 1'b1;
    endtask

    task automatic run(int ncyc);
        for (int i = 0; i < ncyc; i++) one_cycle();
    endtask

    task automatic pi_coefs();
        coef_a = 16'sd5734; coef_b = -16'sd1638; coef_c = 16'sd2048;
        coef_d = -16'sd410; coef_e = -16'sd1229;
    endtask

    initial begin : wd
        repeat (WD_CYC) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", WD_CYC);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        // S1: regular closed loop (R1, R2, R3, R5, R6, R8)
        pi_coefs(); ref_v = 16'sd12000; duty_min = 15'd1000; duty_max = 15'd30000;
        do_reset(5000);
        gap = 3; ack_lat = 1; spacing_exp = RATIO;
        run(400);
        // S2: stray acknowledges while idle are ignored (R3, R8)
        do_reset(20000);
        stray = 1; gap = 2; ack_lat = 0; spacing_exp = RATIO;
        run(300);
        // S3: upper clamp with clamped history (R7)
        coef_a = 16'sd4096; coef_b = 0; coef_c = 16'sd16384; coef_d = 0; coef_e = 0;
        ref_v = 16'sd30000; duty_min = 15'd2000; duty_max = 15'd28000;
        do_reset(3000);
        exp_hi = 1; gap = 3; ack_lat = 2; spacing_exp = RATIO;
        run(250);
        // S4: lower clamp (R7)
        ref_v = -16'sd10000;
        do_reset(3000);
        exp_lo = 1; gap = 3; ack_lat = 1; spacing_exp = RATIO;
        run(250);
        // S5: error saturation, 40000 -> 32767, times 1/16 (R4)
        coef_a = 0; coef_b = 0; coef_c = 16'sd256; coef_d = 0; coef_e = 0;
        ref_v = 16'sd20000; duty_min = 15'd0; duty_max = 15'd32767;
        do_reset(100);
        force_vc = 1; force_val = -20000; exp_val = 2047;
        gap = 2; ack_lat = 1; spacing_exp = RATIO;
        run(250);
        // S6: tick every cycle, slow acknowledge -> boundary dropped (R9)
        pi_coefs(); ref_v = 16'sd9000; duty_min = 15'd500; duty_max = 15'd32000;
        do_reset(4000);
        gap = 1; ack_lat = 4; spacing_exp = 2 * RATIO;
        run(300);
        // S7: tick every cycle, ack at once: ack and publish land on ticks (R2)
        do_reset(4000);
        gap = 1; ack_lat = 0; spacing_exp = RATIO;
        run(200);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule